// File: doc/BRIEF.md
# DMA Interrupt Coalescing Unit

This unit sits beside one channel of a scatter-gather DMA engine and decides when that channel should interrupt the processor. It does not raise an interrupt for every finished packet. A down-counter, loaded from a programmable threshold, raises a completion cause only after that many packet-complete pulses have arrived. A second cause covers the case where traffic stops before the threshold is reached. Every completion restarts an inactivity timer. If the timer runs out before the next completion, it flags a delay cause and re-arms the packet counter.

Software programs the threshold, the timer length, the cause enables and the run bit through one control write port. It acknowledges causes through a status write port that clears each cause written as one. A single status readback word carries the live packet count, the live timer count, both pending causes and the halted flag. The interrupt line is a level. It is high while any pending cause has its enable set. The timer counts down once every `PRESC_DIV` clock cycles.

Top module: `dma_irq_coalesce`

## Requirements
- R1: After reset the status word reads halted (bit 0 = 1), packet count 1 (bits 23:16), timer 0 (bits 31:24) and no pending causes (bits 13:12 = 0), and `irq` is low.
- R2: A control write stores the timer length from bits 31:24, the threshold from bits 23:16 and the cause enables from bits 13:12 (bit 12 completion, bit 13 delay). It reloads the packet count with the new threshold in the next cycle and sets halted to the inverse of bit 0 (the run bit).
- R3: Each packet-complete pulse lowers the count by one. When the result is zero, the completion cause (status bit 12) is set and the count reloads from the threshold. A threshold of 0 therefore needs 256 pulses.
- R4: A packet-complete pulse while the stored timer length is nonzero reloads the timer with that length and restarts its prescaler. With a length of zero, a running timer keeps counting undisturbed.
- R5: A running timer drops by one every `PRESC_DIV` cycles. It reaches zero exactly length × `PRESC_DIV` cycles after the pulse that loaded it. At that moment it sets the delay cause (status bit 13) and reloads the packet count from the threshold.
- R6: `irq` is high exactly when (bit 12 pending and enabled) or (bit 13 pending and enabled). Status bit 14 and enable bit 14 always read and act as zero.
- R7: If the timer expires in the cycle of a packet pulse, the delay cause is set, the count reloads and is then lowered by that pulse, and the timer restarts with the stored length.
- R8: A status write clears each of bits 13:12 written as one and leaves bits written as zero unchanged. A cause set in the same cycle as its clear stays set.
- R9: If a control write and a packet pulse coincide, the count takes the new threshold and the pulse is not counted. The timer restart uses the length stored before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_done | input | 1 | One-cycle pulse per completed packet |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 32 | Control register write data |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 32 | Status write data (bits 13:12 clear causes) |
| sts_rdata | output | 32 | Live status word |
| irq | output | 1 | Level interrupt line |

## Verification
The hardest case to reach is a timer expiry in the very cycle of a packet pulse (R7). To reach it, the bench loads the timer from a pulse and counts exactly length × `PRESC_DIV` cycles. It then drives the next pulse so that it is sampled on the expiry edge and checks the reloaded-then-decremented count. Two other cases are set up with the same edge counting. One is a clear that lands in the same cycle as the count reaching zero. The other is a zero-length pulse arriving mid-countdown, which shows through the timer value two edges later.

// File: rtl/dic_pkg.sv
package dic_pkg;

    localparam int FIELD_W = 8;

    typedef struct packed {
        logic [FIELD_W-1:0] delay;
        logic [FIELD_W-1:0] thresh;
        logic [1:0]         en;
        logic               run;
    } ctrl_fields_t;

    typedef struct packed {
        logic dly;
        logic ioc;
    } cause_t;

    function automatic ctrl_fields_t decode_ctrl(input logic [31:0] w);
        ctrl_fields_t f;
        f.delay  = w[31:24];
        f.thresh = w[23:16];
        f.en     = w[13:12];
        f.run    = w[0];
        return f;
    endfunction

    function automatic logic [31:0] pack_status(input logic [FIELD_W-1:0] tmr,
                                                input logic [FIELD_W-1:0] cnt,
                                                input cause_t             c,
                                                input logic               halted);
        return {tmr, cnt, 2'b00, c.dly, c.ioc, 11'd0, halted};
    endfunction

endpackage

// File: rtl/dic_pkt_counter.sv
module dic_pkt_counter #(
    parameter int W       = 8,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         pkt,
    input  logic         expire,
    input  logic [W-1:0] thresh,
    output logic [W-1:0] cnt,
    output logic         hit
);
    logic [W-1:0] cnt_q, base, dec, nxt;

    always_comb begin
        base = expire ? thresh : cnt_q;
        dec  = base - W'(1);
        hit  = pkt && !load && (dec == '0);
        if (load)        nxt = load_val;
        else if (pkt)    nxt = (dec == '0) ? thresh : dec;
        else if (expire) nxt = thresh;
        else             nxt = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= W'(RST_VAL);
        else     cnt_q <= nxt;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dic_delay_timer.sv
module dic_delay_timer #(
    parameter int W   = 8,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] length,
    output logic [W-1:0] tmr,
    output logic         expire
);
    localparam int PW = $clog2(DIV + 1);

    logic [W-1:0]  tmr_q;
    logic [PW-1:0] presc_q;
    logic          tick;

    assign tick   = (tmr_q != '0) && (presc_q == PW'(DIV - 1));
    assign expire = tick && (tmr_q == W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q   <= '0;
            presc_q <= '0;
        end else if (restart && (length != '0)) begin
            tmr_q   <= length;
            presc_q <= '0;
        end else if (tmr_q != '0) begin
            if (tick) begin
                tmr_q   <= tmr_q - W'(1);
                presc_q <= '0;
            end else begin
                presc_q <= presc_q + PW'(1);
            end
        end
    end

    assign tmr = tmr_q;
endmodule

// File: rtl/dma_irq_coalesce.sv
module dma_irq_coalesce
    import dic_pkg::*;
#(
    parameter int PRESC_DIV = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pkt_done,
    input  logic        ctrl_wr,
    input  logic [31:0] ctrl_wdata,
    input  logic        sts_wr,
    input  logic [31:0] sts_wdata,
    output logic [31:0] sts_rdata,
    output logic        irq
);
    ctrl_fields_t       wr_f;
    logic [FIELD_W-1:0] thr_q, dly_q;
    logic [1:0]         en_q;
    logic               halted_q;
    cause_t             pend_q, pend_nxt;
    logic [FIELD_W-1:0] cnt, tmr;
    logic               hit, expire;
    logic [1:0]         clr;
    logic               unused_wr;

    assign wr_f      = decode_ctrl(ctrl_wdata);
    assign unused_wr = ^{ctrl_wdata[15:14], ctrl_wdata[11:1],
                         sts_wdata[31:14], sts_wdata[11:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q    <= FIELD_W'(1);
            dly_q    <= '0;
            en_q     <= '0;
            halted_q <= 1'b1;
        end else if (ctrl_wr) begin
            thr_q    <= wr_f.thresh;
            dly_q    <= wr_f.delay;
            en_q     <= wr_f.en;
            halted_q <= !wr_f.run;
        end
    end

    dic_pkt_counter #(.W(FIELD_W), .RST_VAL(1)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ctrl_wr),
        .load_val (wr_f.thresh),
        .pkt      (pkt_done),
        .expire   (expire),
        .thresh   (thr_q),
        .cnt      (cnt),
        .hit      (hit)
    );

    dic_delay_timer #(.W(FIELD_W), .DIV(PRESC_DIV)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (pkt_done),
        .length  (dly_q),
        .tmr     (tmr),
        .expire  (expire)
    );

    always_comb begin
        clr          = sts_wr ? sts_wdata[13:12] : 2'b00;
        pend_nxt.dly = (pend_q.dly && !clr[1]) || expire;
        pend_nxt.ioc = (pend_q.ioc && !clr[0]) || hit;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_nxt;
    end

    assign sts_rdata = pack_status(tmr, cnt, pend_q, halted_q);
    assign irq       = (pend_q.ioc && en_q[0]) || (pend_q.dly && en_q[1]);
endmodule

// File: rtl/dma_irq_coalesce_chk.sv
module dma_irq_coalesce_chk (
    input logic        clk,
    input logic        rst,
    input logic        pkt_done,
    input logic        ctrl_wr,
    input logic [31:0] ctrl_wdata,
    input logic        sts_wr,
    input logic [31:0] sts_wdata,
    input logic [31:0] sts_rdata,
    input logic        irq,
    input logic [7:0]  delay_q
);
    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> sts_rdata[23:16] == $past(ctrl_wdata[23:16])); // R2
    AST_IOC_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_rdata[12]) |-> $past(pkt_done)); // R3
    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && delay_q != 8'd0) |=> sts_rdata[31:24] == $past(delay_q)); // R4
    AST_DLY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_rdata[13]) |-> $past(sts_rdata[31:24]) == 8'd1); // R5
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sts_rdata[13:12] == 2'b00) |-> !irq); // R6
    AST_CLEAR_IOC: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && sts_wdata[12] && !pkt_done) |=> !sts_rdata[12]); // R8
endmodule

bind dma_irq_coalesce dma_irq_coalesce_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pkt_done   (pkt_done),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .sts_wr     (sts_wr),
    .sts_wdata  (sts_wdata),
    .sts_rdata  (sts_rdata),
    .irq        (irq),
    .delay_q    (dly_q)
);

// File: tb/dma_irq_coalesce_tb.sv
module dma_irq_coalesce_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pkt_done = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic        sts_wr = 1'b0;
    logic [31:0] sts_wdata = '0;
    logic [31:0] sts_rdata;
    logic        irq;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    string       tq[$];
    logic [31:0] sq[$];
    logic        iq[$];

    always #10 clk = ~clk;

    dma_irq_coalesce #(.PRESC_DIV(4)) u_dut (
        .clk(clk), .rst(rst), .pkt_done(pkt_done),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .sts_rdata(sts_rdata), .irq(irq)
    );

    function automatic logic [31:0] mk(int t, int c, bit d, bit i, bit h);
        logic [7:0] t8, c8;
        t8 = t[7:0];
        c8 = c[7:0];
        return {t8, c8, 2'b00, d, i, 11'd0, h};
    endfunction

    function automatic logic [31:0] cw(int dly, int thr, int en, bit run);
        logic [7:0] d8, t8;
        logic [1:0] e2;
        d8 = dly[7:0];
        t8 = thr[7:0];
        e2 = en[1:0];
        return {d8, t8, 2'b00, e2, 11'd0, run};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_sts(string tag, logic [31:0] s, logic i);
        tq.push_back(tag);
        sq.push_back(s);
        iq.push_back(i);
    endtask

    task automatic ctrl_write(logic [31:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        tick();
        ctrl_wr = 1'b0;
    endtask

    task automatic sts_write(logic [31:0] v);
        sts_wr = 1'b1; sts_wdata = v;
        tick();
        sts_wr = 1'b0;
    endtask

    task automatic pkt();
        pkt_done = 1'b1;
        tick();
        pkt_done = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    always @(negedge clk) begin
        while (tq.size() > 0) begin
            string       tg;
            logic [31:0] es;
            logic        ei;
            tg = tq.pop_front();
            es = sq.pop_front();
            ei = iq.pop_front();
            n_cmp++;
            if (sts_rdata !== es || irq !== ei) begin
                n_bad++;
                $display("FAIL %s: sts=%h irq=%b expected sts=%h irq=%b",
                         tg, sts_rdata, irq, es, ei);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        ticks(3);
        rst = 1'b0;
        tick();
        expect_sts("R1 reset state", mk(0, 1, 0, 0, 1), 1'b0);

        ctrl_write(cw(0, 3, 3, 1));
        expect_sts("R2 threshold load and run", mk(0, 3, 0, 0, 0), 1'b0);
        pkt();
        expect_sts("R3 first decrement", mk(0, 2, 0, 0, 0), 1'b0);
        pkt();
        expect_sts("R3 second decrement", mk(0, 1, 0, 0, 0), 1'b0);
        pkt();
        expect_sts("R3 reach zero sets cause, R6 irq", mk(0, 3, 0, 1, 0), 1'b1);
        sts_write(32'h0000_2000);
        expect_sts("R8 zero bit leaves cause", mk(0, 3, 0, 1, 0), 1'b1);
        sts_write(32'h0000_1000);
        expect_sts("R8 one bit clears cause", mk(0, 3, 0, 0, 0), 1'b0);

        ctrl_write(cw(0, 2, 0, 1));
        pkt();
        pkt();
        expect_sts("R6 disabled cause keeps irq low", mk(0, 2, 0, 1, 0), 1'b0);
        sts_write(32'h0000_3000);

        ctrl_write(cw(3, 5, 2, 1));
        expect_sts("R2 new threshold", mk(0, 5, 0, 0, 0), 1'b0);
        pkt();
        expect_sts("R4 timer loaded", mk(3, 4, 0, 0, 0), 1'b0);
        ticks(4);
        expect_sts("R5 first timer step", mk(2, 4, 0, 0, 0), 1'b0);
        ticks(7);
        expect_sts("R5 one step before expiry", mk(1, 4, 0, 0, 0), 1'b0);
        tick();
        expect_sts("R5 expiry sets cause and reloads", mk(0, 5, 1, 0, 0), 1'b1);
        sts_write(32'h0000_2000);
        expect_sts("R8 clear delay cause", mk(0, 5, 0, 0, 0), 1'b0);

        ctrl_write(cw(3, 5, 0, 1));
        pkt();
        expect_sts("R4 timer loaded again", mk(3, 4, 0, 0, 0), 1'b0);
        ctrl_write(cw(0, 5, 0, 1));
        expect_sts("R2 write leaves timer running", mk(3, 5, 0, 0, 0), 1'b0);
        pkt();
        ticks(2);
        expect_sts("R4 zero length does not restart", mk(2, 4, 0, 0, 0), 1'b0);
        ticks(8);
        expect_sts("R5 expiry of unrestarted timer", mk(0, 5, 1, 0, 0), 1'b0);
        sts_write(32'h0000_3000);

        ctrl_write(cw(2, 3, 3, 1));
        pkt();
        expect_sts("R4 timer length 2", mk(2, 2, 0, 0, 0), 1'b0);
        ticks(7);
        pkt();
        expect_sts("R7 expiry with pulse", mk(2, 2, 1, 0, 0), 1'b1);

        ctrl_wr = 1'b1; ctrl_wdata = cw(0, 4, 0, 1); pkt_done = 1'b1;
        tick();
        ctrl_wr = 1'b0; pkt_done = 1'b0;
        expect_sts("R9 write wins over pulse", mk(2, 4, 1, 0, 0), 1'b0);
        ticks(10);
        sts_write(32'h0000_3000);
        expect_sts("R9 timer ran out after old length", mk(0, 4, 0, 0, 0), 1'b0);

        ctrl_write(cw(0, 0, 0, 1));
        expect_sts("R2 threshold zero", mk(0, 0, 0, 0, 0), 1'b0);
        pkt();
        expect_sts("R3 zero threshold wraps", mk(0, 255, 0, 0, 0), 1'b0);
        for (int k = 0; k < 255; k++) pkt();
        expect_sts("R3 256th pulse sets cause", mk(0, 0, 0, 1, 0), 1'b0);

        ctrl_write(cw(0, 1, 1, 1));
        expect_sts("R6 enable pending cause", mk(0, 1, 0, 1, 0), 1'b1);
        sts_wr = 1'b1; sts_wdata = 32'h0000_1000; pkt_done = 1'b1;
        tick();
        sts_wr = 1'b0; pkt_done = 1'b0;
        expect_sts("R8 set wins over clear", mk(0, 1, 0, 1, 0), 1'b1);
        sts_write(32'h0000_1000);
        expect_sts("R8 clear after collision", mk(0, 1, 0, 0, 0), 1'b0);

        ctrl_write(cw(0, 1, 1, 0));
        expect_sts("R2 run bit low sets halted", mk(0, 1, 0, 0, 1), 1'b0);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule